// File: doc/BRIEF.md
# E1 Time Slot 16 Signaling Inserter

This block sits in the transmit path of an E1 framer. It places channel-associated signaling that the host supplies into time slot 16 of a bit-serial outgoing stream. The host writes sixteen 8-bit signaling registers through a simple register port at addresses `BASE_ADDR` to `BASE_ADDR+15`. The first register holds the multiframe word. Each of the other registers packs the four signaling bits of two voice channels.

At every multiframe boundary the block copies all sixteen registers into an internal signaling buffer. During frame k of the multiframe, time slot 16 carries buffer byte k. Writes made while a multiframe is being sent therefore never tear it.

A sticky multiframe flag tells the host when to refresh the registers. The flag can pull a shared active-low interrupt through its own enable. When insertion is disabled, the stream passes through untouched.

Top module: `e1cas_tx_insert`

## Requirements
- R1: After reset, every register and the status word read 0, `irq_n` is 1 and `dout_vld` is 0.
- R2: A write to `BASE_ADDR+j` (j = 0..15) stores the byte, and reading that address returns it. Any address that is neither a signaling register nor `STAT_ADDR` reads 0.
- R3: With `ins_en` = 1, bit b (b = 0..7) of time slot 16 in frame k (k = 0..15) is bit 7-b of buffer byte k, so the byte is sent MSB first. Time slot 16 covers stream bit positions 128..135 of a 256-bit frame.
- R4: With `ins_en` = 0, every output bit equals the input bit one cycle earlier, time slot 16 included.
- R5: Bits outside time slot 16 always pass through unchanged, whatever the value of `ins_en`.
- R6: The buffer is loaded only at the multiframe boundary, which is bit 0 of frame 0. A register write during a multiframe, including one in the boundary cycle, shows only in the next multiframe.
- R7: The status flag, bit 0 of the word at `STAT_ADDR`, is set at every multiframe boundary and holds until a read of `STAT_ADDR` clears it. A boundary in the same cycle as that read leaves the flag set.
- R8: `irq_n` is 0 exactly when the status flag is 1 and `irq_en` is 1.
- R9: A valid bit presented with `mf_sync` = 1 is taken as bit 0 of frame 0, whatever the free-running position. Without `mf_sync`, the position wraps every 4096 valid bits.
- R10: Every cycle with `bit_vld` = 1 gives one output bit on `dout` with `dout_vld` = 1 in the next cycle. A cycle without `bit_vld` gives `dout_vld` = 0 in the next cycle and does not advance the position.
- R11: Bits 7..4 of the register at `BASE_ADDR` are the multiframe alignment pattern 0000. They ignore writes and always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; clears the status flag when it addresses `STAT_ADDR` |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| ins_en | input | 1 | Enables insertion into time slot 16 |
| irq_en | input | 1 | Interrupt enable for the multiframe flag |
| irq_n | output | 1 | Active-low interrupt |
| bit_vld | input | 1 | Marks a valid stream bit on `din` |
| mf_sync | input | 1 | Marks the current valid bit as bit 0 of frame 0 |
| din | input | 1 | Incoming serial stream |
| dout_vld | output | 1 | Marks a valid bit on `dout` |
| dout | output | 1 | Outgoing serial stream |

## Verification
A position counter that is out of step moves the inserted bits away from positions 128..135. That corrupts both the time slot 16 check and the pass-through check within the first frame, at most 256 valid bits later. A buffer that reloads at the wrong moment shows up as a deferred write appearing too early, in the multiframe where it was made. A flag that is set or cleared at the wrong time shows on `irq_n` in the cycle after the fault, and in the next read of the status word.

// File: rtl/e1cas_pkg.sv
package e1cas_pkg;
   localparam int unsigned MF_FRAMES = 16;
   localparam int unsigned OCTET     = 8;
   localparam int unsigned FRM_W     = $clog2(MF_FRAMES);
   localparam int unsigned OCT_W     = $clog2(OCTET);

   // Position of the bit currently presented on the stream input
   typedef struct packed {
      logic             vld;        // a bit is present this cycle
      logic             mf_start;   // bit 0 of frame 0
      logic             in_slot;    // bit lies inside the signaling slot
      logic [OCT_W-1:0] slot_bit;   // 0 = first (MSB) bit of the slot
      logic [FRM_W-1:0] frame;      // frame number inside the multiframe
   } pos_t;
endpackage

// File: rtl/e1cas_position.sv
module e1cas_position
   import e1cas_pkg::*;
#(
   parameter int unsigned SLOTS    = 32,
   parameter int unsigned SIG_SLOT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_vld,
   input  logic mf_sync,
   output pos_t pos
);
   localparam int unsigned FRAME_BITS = SLOTS * OCTET;
   localparam int unsigned BIT_W      = $clog2(FRAME_BITS);
   localparam int unsigned SLOT_LO    = SIG_SLOT * OCTET;
   localparam int unsigned SLOT_HI    = SLOT_LO + OCTET - 1;

   generate
      if (SIG_SLOT >= SLOTS) begin : g_bad_slot
         $error("SIG_SLOT must lie inside the frame");
      end
      if (FRAME_BITS != (1 << BIT_W)) begin : g_bad_frame
         $error("SLOTS * 8 must be a power of two");
      end
   endgenerate

   logic [BIT_W-1:0] cnt_bit_q;
   logic [FRM_W-1:0] cnt_frm_q;
   logic [BIT_W-1:0] cur_bit;
   logic [FRM_W-1:0] cur_frm;
   logic [BIT_W-1:0] slot_off;

   // A sync pulse overrides the free-running position
   always_comb begin
      cur_bit = mf_sync ? '0 : cnt_bit_q;
      cur_frm = mf_sync ? '0 : cnt_frm_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_bit_q <= '0;
         cnt_frm_q <= '0;
      end else if (bit_vld) begin
         if (cur_bit == BIT_W'(FRAME_BITS - 1)) begin
            cnt_bit_q <= '0;
            cnt_frm_q <= (cur_frm == FRM_W'(MF_FRAMES - 1)) ? '0 : cur_frm + 1'b1;
         end else begin
            cnt_bit_q <= cur_bit + 1'b1;
            cnt_frm_q <= cur_frm;
         end
      end
   end

   always_comb begin
      slot_off     = cur_bit - BIT_W'(SLOT_LO);
      pos.vld      = bit_vld;
      pos.mf_start = (cur_bit == '0) && (cur_frm == '0);
      pos.in_slot  = (cur_bit >= BIT_W'(SLOT_LO)) && (cur_bit <= BIT_W'(SLOT_HI));
      pos.slot_bit = slot_off[OCT_W-1:0];
      pos.frame    = cur_frm;
   end
endmodule

// File: rtl/e1cas_regfile.sv
module e1cas_regfile
   import e1cas_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned BASE_ADDR = 'h40,
   parameter int unsigned STAT_ADDR = 'h50,
   parameter int unsigned NREGS     = MF_FRAMES
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr,
   input  logic                     rd,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [OCTET-1:0]         wdata,
   output logic [OCTET-1:0]         rdata,
   input  logic                     mf_load,
   output logic                     flag,
   output logic [NREGS*OCTET-1:0]   regs_flat
);
   generate
      if (BASE_ADDR + NREGS > (1 << ADDR_W)) begin : g_bad_base
         $error("register window exceeds the address space");
      end
      if (STAT_ADDR >= BASE_ADDR && STAT_ADDR < BASE_ADDR + NREGS) begin : g_bad_stat
         $error("status address overlaps the register window");
      end
   endgenerate

   genvar g;
   generate
      for (g = 0; g < NREGS; g++) begin : g_reg
         logic hit;
         assign hit = wr && (addr == ADDR_W'(BASE_ADDR + g));
         if (g == 0) begin : g_mfw
            // Upper nibble is the fixed alignment pattern
            logic [3:0] lo_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   lo_q <= '0;
               else if (hit) lo_q <= wdata[3:0];
            end
            assign regs_flat[OCTET-1:0] = {4'b0000, lo_q};
         end else begin : g_chan
            logic [OCTET-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   q <= '0;
               else if (hit) q <= wdata;
            end
            assign regs_flat[g*OCTET +: OCTET] = q;
         end
      end
   endgenerate

   logic stat_rd;
   assign stat_rd = rd && (addr == ADDR_W'(STAT_ADDR));

   // Sticky flag; a boundary in the same cycle as the clearing read wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag <= 1'b0;
      else if (mf_load) flag <= 1'b1;
      else if (stat_rd) flag <= 1'b0;
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(STAT_ADDR)) rdata = {{(OCTET-1){1'b0}}, flag};
      for (int i = 0; i < NREGS; i++) begin
         if (addr == ADDR_W'(BASE_ADDR + i)) rdata = regs_flat[i*OCTET +: OCTET];
      end
   end
endmodule

// File: rtl/e1cas_sigbuf.sv
module e1cas_sigbuf
   import e1cas_pkg::*;
#(
   parameter int unsigned NREGS = MF_FRAMES
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   mf_load,
   input  logic [NREGS*OCTET-1:0] regs_flat,
   input  pos_t                   pos,
   output logic [NREGS*OCTET-1:0] sig_q,
   output logic                   sig_bit
);
   localparam int unsigned IDX_W = $clog2(NREGS * OCTET);

   generate
      if (NREGS != MF_FRAMES) begin : g_bad_depth
         $error("one signaling byte is needed per frame");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sig_q <= '0;
      else if (mf_load) sig_q <= regs_flat;
   end

   // Byte k sits at bits [8k+7:8k]; slot bit b selects bit 7-b
   logic [IDX_W-1:0] sel;
   assign sel     = {pos.frame, ~pos.slot_bit};
   assign sig_bit = sig_q[sel];
endmodule

// File: rtl/e1cas_tx_insert.sv
module e1cas_tx_insert
   import e1cas_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned BASE_ADDR = 'h40,
   parameter int unsigned STAT_ADDR = 'h50,
   parameter int unsigned SLOTS     = 32,
   parameter int unsigned SIG_SLOT  = 16,
   parameter bit          OUT_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              ins_en,
   input  logic              irq_en,
   output logic              irq_n,
   input  logic              bit_vld,
   input  logic              mf_sync,
   input  logic              din,
   output logic              dout_vld,
   output logic              dout
);
   localparam int unsigned NREGS = MF_FRAMES;

   pos_t                   pos;
   logic                   mf_load;
   logic                   stat_flag;
   logic                   sig_bit;
   logic [NREGS*OCTET-1:0] regs_flat;
   logic [NREGS*OCTET-1:0] sig_q;
   logic                   nxt_bit;

   e1cas_position #(.SLOTS(SLOTS), .SIG_SLOT(SIG_SLOT)) u_pos (
      .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .mf_sync(mf_sync), .pos(pos)
   );

   assign mf_load = pos.vld && pos.mf_start;

   e1cas_regfile #(
      .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .STAT_ADDR(STAT_ADDR), .NREGS(NREGS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .mf_load(mf_load), .flag(stat_flag),
      .regs_flat(regs_flat)
   );

   e1cas_sigbuf #(.NREGS(NREGS)) u_sbuf (
      .clk(clk), .rst_n(rst_n), .mf_load(mf_load), .regs_flat(regs_flat),
      .pos(pos), .sig_q(sig_q), .sig_bit(sig_bit)
   );

   assign nxt_bit = (ins_en && pos.in_slot) ? sig_bit : din;
   assign irq_n   = !(stat_flag && irq_en);

   generate
      if (OUT_REG) begin : g_oreg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dout_vld <= 1'b0;
               dout     <= 1'b0;
            end else begin
               dout_vld <= bit_vld;
               dout     <= bit_vld ? nxt_bit : 1'b0;
            end
         end
      end else begin : g_ocomb
         assign dout_vld = bit_vld;
         assign dout     = bit_vld ? nxt_bit : 1'b0;
      end
   endgenerate
endmodule

// File: rtl/e1cas_tx_insert_chk.sv
module e1cas_tx_insert_chk #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned BASE_ADDR = 'h40,
   parameter int unsigned STAT_ADDR = 'h50,
   parameter int unsigned BUF_W     = 128,
   parameter bit          OUT_REG   = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bit_vld,
   input logic              mf_sync,
   input logic              din,
   input logic              ins_en,
   input logic              irq_en,
   input logic              irq_n,
   input logic              dout_vld,
   input logic              dout,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [7:0]        reg_rdata,
   input logic              stat_flag,
   input logic              mf_load,
   input logic [BUF_W-1:0]  sig_q
);
   generate
      if (OUT_REG) begin : g_lat
         a_r10_vld_lag: assert property (@(posedge clk) disable iff (!rst_n)
            bit_vld |=> dout_vld);
         a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !bit_vld |=> !dout_vld);
         a_r4_bypass: assert property (@(posedge clk) disable iff (!rst_n)
            (bit_vld && !ins_en) |=> (dout == $past(din)));
      end
   endgenerate

   a_r7_sync_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_vld && mf_sync) |=> stat_flag);
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_flag && !(reg_rd && reg_addr == ADDR_W'(STAT_ADDR))) |=> stat_flag);
   a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> irq_n);
   a_r8_raise: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && stat_flag) |-> !irq_n);
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !mf_load |=> $stable(sig_q));
   a_r11_mfw: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(BASE_ADDR)) |-> (reg_rdata[7:4] == 4'h0));
endmodule

bind e1cas_tx_insert e1cas_tx_insert_chk #(
   .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .STAT_ADDR(STAT_ADDR),
   .BUF_W(NREGS * e1cas_pkg::OCTET), .OUT_REG(OUT_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .mf_sync(mf_sync), .din(din),
   .ins_en(ins_en), .irq_en(irq_en), .irq_n(irq_n), .dout_vld(dout_vld),
   .dout(dout), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
   .stat_flag(stat_flag), .mf_load(mf_load), .sig_q(sig_q)
);

// File: tb/tb_e1cas_tx_insert.sv
module tb_e1cas_tx_insert;
   localparam int BASE = 'h40;
   localparam int STAT = 'h50;
   localparam int MF_BITS = 4096;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0] reg_addr = '0, reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       ins_en = 1'b0, irq_en = 1'b0;
   logic       irq_n;
   logic       bit_vld = 1'b0, mf_sync = 1'b0, din = 1'b0;
   logic       dout_vld, dout;

   int n_chk = 0;
   int n_fail = 0;

   logic [7:0] mreg [16];
   logic [7:0] mbuf [16];

   always #2 clk = ~clk;

   e1cas_tx_insert dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ins_en(ins_en), .irq_en(irq_en), .irq_n(irq_n), .bit_vld(bit_vld),
      .mf_sync(mf_sync), .din(din), .dout_vld(dout_vld), .dout(dout)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic host_write(input int a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 8'(a); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      if (a >= BASE && a < BASE + 16) mreg[a-BASE] = (a == BASE) ? (d & 8'h0F) : d;
   endtask

   task automatic host_read(input int a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = 8'(a); reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   function automatic logic pat(input int idx, input int seed);
      return 1'(((idx * 37) ^ (idx >> 3) ^ seed) & 1);
   endfunction

   // op: 0 none, 1 write, 2 read
   task automatic run_mf(input bit en, input bit sync, input int op, input int op_idx,
                         input int op_addr, input logic [7:0] op_data, input int seed,
                         input string sig_tag);
      int errs_sig = 0, errs_oth = 0, errs_vld = 0;
      int first_act = 0, first_exp = 0;
      logic prev_exp = 1'b0;
      bit prev_sig = 1'b0;
      ins_en = en;
      for (int idx = 0; idx < MF_BITS; idx++) begin
         int fr, b;
         logic dv, ex;
         bit insig;
         @(negedge clk);
         if (idx > 0) begin
            if (!dout_vld) errs_vld++;
            if (dout !== prev_exp) begin
               if (prev_sig) errs_sig++; else errs_oth++;
               first_act = int'(dout); first_exp = int'(prev_exp);
            end
         end
         fr = idx / 256; b = idx % 256;
         if (idx == 0) mbuf = mreg;
         reg_wr = 1'b0; reg_rd = 1'b0;
         if (idx == op_idx && op == 1) begin
            reg_wr = 1'b1; reg_addr = 8'(op_addr); reg_wdata = op_data;
            mreg[op_addr-BASE] = (op_addr == BASE) ? (op_data & 8'h0F) : op_data;
         end
         if (idx == op_idx && op == 2) begin
            reg_rd = 1'b1; reg_addr = 8'(op_addr);
         end
         dv = pat(idx, seed);
         bit_vld = 1'b1; din = dv; mf_sync = sync && (idx == 0);
         insig = (b >= 128) && (b <= 135);
         ex = (en && insig) ? mbuf[fr][7-(b-128)] : dv;
         prev_exp = ex; prev_sig = insig;
      end
      @(negedge clk);
      if (!dout_vld) errs_vld++;
      if (dout !== prev_exp) begin
         if (prev_sig) errs_sig++; else errs_oth++;
      end
      bit_vld = 1'b0; mf_sync = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
      @(negedge clk);
      if (dout_vld) errs_vld++;
      check(errs_sig == 0, sig_tag, first_act, first_exp);
      check(errs_oth == 0, "R5 bits outside slot 16 pass through", first_act, first_exp);
      check(errs_vld == 0, "R10 output valid lags input by one cycle", errs_vld, 0);
   endtask

   task automatic run_partial(input int n);
      for (int idx = 0; idx < n; idx++) begin
         @(negedge clk);
         if (idx == 0) mbuf = mreg;
         bit_vld = 1'b1; din = pat(idx, 3); mf_sync = 1'b0;
      end
      @(negedge clk);
      bit_vld = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check(irq_n === 1'b1, "R1 irq_n high after reset", int'(irq_n), 1);
      check(dout_vld === 1'b0, "R1 dout_vld low after reset", int'(dout_vld), 0);
      host_read(BASE + 5, d);
      check(d === 8'h00, "R1 register reads zero after reset", d, 0);
      host_read(STAT, d);
      check(d === 8'h00, "R1 status zero after reset", d, 0);
   endtask

   task automatic t_regs();
      logic [7:0] d;
      int bad = 0;
      for (int j = 1; j < 16; j++) host_write(BASE + j, 8'(8'h5A ^ (j * 29)));
      host_write(BASE, 8'hFF);
      for (int j = 1; j < 16; j++) begin
         host_read(BASE + j, d);
         if (d !== mreg[j]) bad++;
      end
      check(bad == 0, "R2 signaling registers read back", bad, 0);
      host_read(BASE, d);
      check(d === 8'h0F, "R11 alignment nibble ignores writes", d, 8'h0F);
      host_read(BASE - 1, d);
      check(d === 8'h00, "R2 unmapped address reads zero", d, 0);
   endtask

   task automatic t_bypass();
      logic [7:0] d;
      irq_en = 1'b0;
      run_mf(1'b0, 1'b1, 0, -1, 0, 8'h00, 1, "R4 slot 16 passes through when disabled");
      check(irq_n === 1'b1, "R8 masked flag keeps irq_n high", int'(irq_n), 1);
      host_read(STAT, d);
      check(d === 8'h01, "R7 flag set at boundary", d, 1);
      host_read(STAT, d);
      check(d === 8'h00, "R7 read clears flag", d, 0);
   endtask

   task automatic t_insert_defer();
      run_mf(1'b1, 1'b1, 1, 2000, BASE + 6, 8'hC3, 2,
             "R3 slot 16 carries buffered bytes, R6 mid write deferred");
      irq_en = 1'b1;
      run_mf(1'b1, 1'b0, 1, 0, BASE + 9, 8'h3C, 4,
             "R6 write lands next multiframe, R9 free-running wrap");
      check(irq_n === 1'b0, "R8 irq_n low with flag and enable", int'(irq_n), 0);
   endtask

   task automatic t_flag_race();
      logic [7:0] d;
      host_read(STAT, d);
      check(irq_n === 1'b1, "R8 irq_n released after clearing read", int'(irq_n), 1);
      irq_en = 1'b0;
      run_mf(1'b1, 1'b0, 2, 0, STAT, 8'h00, 5, "R3 insertion with read at boundary");
      host_read(STAT, d);
      check(d === 8'h01, "R7 boundary wins over same-cycle read", d, 1);
      run_mf(1'b1, 1'b0, 2, 100, STAT, 8'h00, 6, "R3 insertion with later read");
      host_read(STAT, d);
      check(d === 8'h00, "R7 later read clears flag", d, 0);
   endtask

   task automatic t_resync();
      host_write(BASE + 1, 8'hE7);
      host_write(BASE + 15, 8'h81);
      run_partial(1000);
      run_mf(1'b1, 1'b1, 0, -1, 0, 8'h00, 7, "R9 mf_sync realigns position");
   endtask

   initial begin
      for (int j = 0; j < 16; j++) begin
         mreg[j] = '0; mbuf[j] = '0;
      end
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_bypass();
      t_insert_defer();
      t_flag_race();
      t_resync();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(4 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule